// File: doc/BRIEF.md
# Sequence Number Tracker for a Bit-Oriented Link Secondary

This block holds the two modulo-8 sequence counters that a secondary station keeps on a bit-oriented synchronous data link, together with two sticky error flags. The send counter advances each time the station puts an information frame on the line. The receive counter advances each time an information frame arrives carrying the expected send number. The block also judges the acknowledge number in every received frame against the local send counter.

Upstream frame logic presents each received frame as a single-cycle strobe carrying the frame's send and receive fields and a flag saying whether the frame is an information frame. The transmit path pulses a strobe per information frame sent. All state lives in one 8-bit register. A processor can read it at any time, overwrite it as a byte, or set or clear any single bit. A processor access wins over the frame-driven update for the bits it touches.

Top module: `seqtrk_top`

## Requirements
- R1: While `rst_n` is low the register is held at 0x00, and the first cycle after reset reads 0x00.
- R2: `stat_q` bits 7..5 hold the send counter (bit 7 most significant), bit 4 is the send-side error flag, bits 3..1 hold the receive counter (bit 3 most significant) and bit 0 is the receive-side error flag.
- R3: Each cycle with `tx_info` high advances the send counter by one modulo 8 (7 wraps to 0).
- R4: A received information frame (`rx_valid` and `rx_is_info` high) whose `rx_ns` equals the receive counter advances the receive counter by one modulo 8 and leaves the receive-side error flag unchanged.
- R5: A received information frame whose `rx_ns` differs from the receive counter sets the receive-side error flag and leaves the receive counter unchanged.
- R6: Any received frame whose `rx_nr` equals neither the send counter nor the send counter plus one modulo 8 sets the send-side error flag; a match leaves it unchanged. The compare uses the send counter value held before any same-cycle `tx_info` increment.
- R7: A received frame with `rx_is_info` low changes neither the receive counter nor the receive-side error flag.
- R8: Both error flags are sticky: once set, frame activity never clears them; only reset or a processor access does.
- R9: A cycle with `cpu_wr_en` high loads `cpu_wr_data` into the whole register, overriding any frame-driven update in that cycle.
- R10: A cycle with `cpu_bit_en` high forces bit `cpu_bit_sel` to `cpu_bit_val`; this wins over a same-cycle byte write for that bit, and the other bits follow their normal update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a received frame |
| rx_is_info | input | 1 | Received frame is an information frame |
| rx_ns | input | 3 | Send number carried by the received frame |
| rx_nr | input | 3 | Receive (acknowledge) number carried by the received frame |
| tx_info | input | 1 | One-cycle strobe per transmitted information frame |
| cpu_wr_en | input | 1 | Processor byte write enable |
| cpu_wr_data | input | 8 | Processor byte write data |
| cpu_bit_en | input | 1 | Processor single-bit write enable |
| cpu_bit_sel | input | 3 | Bit index for the single-bit write |
| cpu_bit_val | input | 1 | Value for the single-bit write |
| stat_q | output | 8 | Register contents |

## Verification
The hardest case to reach is the acknowledge window around the counter wrap: proving that an acknowledge of 0 is accepted while the send counter is 7, and that the window is taken from the counter before a simultaneous transmit increment. The stimulus gets there by preloading the send counter with a byte write instead of stepping it seven times, then sending supervisory frames with chosen acknowledge numbers, once with `tx_info` pulsed in the same cycle. Collisions between processor writes, bit operations and frame strobes in one cycle are also driven directly, and a long mixed random run is checked cycle by cycle against the bench model.

// File: rtl/seqtrk_pkg.sv
// Package: shared field-position helpers for the sequence tracker register.
// Assumes the layout {send counter, send flag, receive counter, receive flag}
// from MSB to LSB, with both counters SEQ_W bits wide.
package seqtrk_pkg;

    localparam int SEQ_W_DEF = 3;

    // Total register width for a given counter width.
    function automatic int reg_width(input int seq_w);
        return 2 * seq_w + 2;
    endfunction

    // Bit position of the receive-side error flag.
    function automatic int pos_rflag(input int seq_w);
        return 0;
    endfunction

    // Lowest bit of the receive counter.
    function automatic int pos_rcnt(input int seq_w);
        return 1;
    endfunction

    // Bit position of the send-side error flag.
    function automatic int pos_sflag(input int seq_w);
        return seq_w + 1;
    endfunction

    // Lowest bit of the send counter.
    function automatic int pos_scnt(input int seq_w);
        return seq_w + 2;
    endfunction

endpackage

// File: rtl/seqtrk_send_side.sv
// Module: next-state logic for the send counter and the send-side error flag.
// Assumes tx_info and rx_valid are single-cycle strobes. The acknowledge
// window {ns, ns+1} is taken from the counter value before any increment.
module seqtrk_send_side #(
    parameter int SEQ_W = 3
) (
    input  logic [SEQ_W-1:0] ns_q,
    input  logic             sflag_q,
    input  logic             tx_info,
    input  logic             rx_valid,
    input  logic [SEQ_W-1:0] rx_nr,
    output logic [SEQ_W-1:0] ns_d,
    output logic             sflag_d
);

    logic [SEQ_W-1:0] ns_plus1;
    logic             ack_in_window;

    // Counter advance and acknowledge window test.
    always_comb begin
        ns_plus1      = ns_q + {{(SEQ_W-1){1'b0}}, 1'b1};
        ack_in_window = (rx_nr == ns_q) || (rx_nr == ns_plus1);
        ns_d          = tx_info ? ns_plus1 : ns_q;
        sflag_d       = sflag_q | (rx_valid & ~ack_in_window);
    end

endmodule

// File: rtl/seqtrk_recv_side.sv
// Module: next-state logic for the receive counter and receive-side error flag.
// Assumes only information frames carry a meaningful send number; other
// frames leave this side untouched.
module seqtrk_recv_side #(
    parameter int SEQ_W = 3
) (
    input  logic [SEQ_W-1:0] nr_q,
    input  logic             rflag_q,
    input  logic             rx_valid,
    input  logic             rx_is_info,
    input  logic [SEQ_W-1:0] rx_ns,
    output logic [SEQ_W-1:0] nr_d,
    output logic             rflag_d
);

    logic info_frame;
    logic in_order;

    // In-order frames advance the counter; out-of-order ones raise the flag.
    always_comb begin
        info_frame = rx_valid & rx_is_info;
        in_order   = (rx_ns == nr_q);
        nr_d       = nr_q;
        rflag_d    = rflag_q;
        if (info_frame) begin
            if (in_order) begin
                nr_d = nr_q + {{(SEQ_W-1){1'b0}}, 1'b1};
            end else begin
                rflag_d = 1'b1;
            end
        end
    end

endmodule

// File: rtl/seqtrk_cpu_merge.sv
// Module: per-bit merge of processor accesses over the frame-driven update.
// Priority per bit: single-bit write, then byte write, then frame update.
module seqtrk_cpu_merge #(
    parameter int REG_W = 8,
    localparam int SEL_W = $clog2(REG_W)
) (
    input  logic [REG_W-1:0] hw_d,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             bit_en,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             bit_val,
    output logic [REG_W-1:0] reg_d
);

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        logic hit;
        // Select the winning source for bit i.
        always_comb begin
            hit = bit_en && (bit_sel == SEL_W'(i));
            if (hit) begin
                reg_d[i] = bit_val;
            end else if (wr_en) begin
                reg_d[i] = wr_data[i];
            end else begin
                reg_d[i] = hw_d[i];
            end
        end
    end

endmodule

// File: rtl/seqtrk_top.sv
// Module: sequence number tracker for a link secondary station.
// Holds send/receive counters and sticky error flags in one register with
// processor byte and bit access. Assumes all strobes are synchronous to clk.
module seqtrk_top #(
    parameter int SEQ_W = seqtrk_pkg::SEQ_W_DEF,
    localparam int REG_W = seqtrk_pkg::reg_width(SEQ_W),
    localparam int SEL_W = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_is_info,
    input  logic [SEQ_W-1:0] rx_ns,
    input  logic [SEQ_W-1:0] rx_nr,
    input  logic             tx_info,
    input  logic             cpu_wr_en,
    input  logic [REG_W-1:0] cpu_wr_data,
    input  logic             cpu_bit_en,
    input  logic [SEL_W-1:0] cpu_bit_sel,
    input  logic             cpu_bit_val,
    output logic [REG_W-1:0] stat_q
);

    localparam int P_RF = seqtrk_pkg::pos_rflag(SEQ_W);
    localparam int P_RC = seqtrk_pkg::pos_rcnt(SEQ_W);
    localparam int P_SF = seqtrk_pkg::pos_sflag(SEQ_W);
    localparam int P_SC = seqtrk_pkg::pos_scnt(SEQ_W);

    logic [REG_W-1:0] stat_r;
    logic [REG_W-1:0] hw_d;
    logic [REG_W-1:0] reg_d;
    logic [SEQ_W-1:0] ns_d;
    logic [SEQ_W-1:0] nr_d;
    logic             sflag_d;
    logic             rflag_d;

    seqtrk_send_side #(.SEQ_W(SEQ_W)) u_send (
        .ns_q     (stat_r[P_SC +: SEQ_W]),
        .sflag_q  (stat_r[P_SF]),
        .tx_info  (tx_info),
        .rx_valid (rx_valid),
        .rx_nr    (rx_nr),
        .ns_d     (ns_d),
        .sflag_d  (sflag_d)
    );

    seqtrk_recv_side #(.SEQ_W(SEQ_W)) u_recv (
        .nr_q       (stat_r[P_RC +: SEQ_W]),
        .rflag_q    (stat_r[P_RF]),
        .rx_valid   (rx_valid),
        .rx_is_info (rx_is_info),
        .rx_ns      (rx_ns),
        .nr_d       (nr_d),
        .rflag_d    (rflag_d)
    );

    // Pack the frame-driven next values into register layout.
    always_comb begin
        hw_d                  = '0;
        hw_d[P_SC +: SEQ_W]   = ns_d;
        hw_d[P_SF]            = sflag_d;
        hw_d[P_RC +: SEQ_W]   = nr_d;
        hw_d[P_RF]            = rflag_d;
    end

    seqtrk_cpu_merge #(.REG_W(REG_W)) u_merge (
        .hw_d    (hw_d),
        .wr_en   (cpu_wr_en),
        .wr_data (cpu_wr_data),
        .bit_en  (cpu_bit_en),
        .bit_sel (cpu_bit_sel),
        .bit_val (cpu_bit_val),
        .reg_d   (reg_d)
    );

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_r <= '0;
        end else begin
            stat_r <= reg_d;
        end
    end

    assign stat_q = stat_r;

endmodule

// File: rtl/seqtrk_checker.sv
// Module: temporal checks on the tracker's ports, attached by bind.
// Assumes the default layout helpers from seqtrk_pkg.
module seqtrk_checker #(
    parameter int SEQ_W = 3,
    localparam int REG_W = seqtrk_pkg::reg_width(SEQ_W),
    localparam int SEL_W = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_is_info,
    input  logic [SEQ_W-1:0] rx_ns,
    input  logic [SEQ_W-1:0] rx_nr,
    input  logic             tx_info,
    input  logic             cpu_wr_en,
    input  logic [REG_W-1:0] cpu_wr_data,
    input  logic             cpu_bit_en,
    input  logic [SEL_W-1:0] cpu_bit_sel,
    input  logic             cpu_bit_val,
    input  logic [REG_W-1:0] stat_q
);

    localparam int P_RF = seqtrk_pkg::pos_rflag(SEQ_W);
    localparam int P_RC = seqtrk_pkg::pos_rcnt(SEQ_W);
    localparam int P_SF = seqtrk_pkg::pos_sflag(SEQ_W);
    localparam int P_SC = seqtrk_pkg::pos_scnt(SEQ_W);

    logic             cpu_idle;
    logic [SEQ_W-1:0] ns_v;
    logic [SEQ_W-1:0] nr_v;
    logic [SEQ_W-1:0] one;

    // Field views for readability.
    always_comb begin
        cpu_idle = !cpu_wr_en && !cpu_bit_en;
        ns_v     = stat_q[P_SC +: SEQ_W];
        nr_v     = stat_q[P_RC +: SEQ_W];
        one      = {{(SEQ_W-1){1'b0}}, 1'b1};
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst_n) == 1'b0 |-> stat_q == '0);

    a_r3_send_advance: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_idle && tx_info |=> ns_v == $past(ns_v) + one);

    a_r4_recv_advance: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_idle && rx_valid && rx_is_info && rx_ns == nr_v
        |=> nr_v == $past(nr_v) + one && stat_q[P_RF] == $past(stat_q[P_RF]));

    a_r5_recv_error: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_idle && rx_valid && rx_is_info && rx_ns != nr_v
        |=> stat_q[P_RF] && nr_v == $past(nr_v));

    a_r6_send_error: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_idle && rx_valid && rx_nr != ns_v && rx_nr != ns_v + one
        |=> stat_q[P_SF]);

    a_r6_ack_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_idle && !stat_q[P_SF] && (!rx_valid || rx_nr == ns_v || rx_nr == ns_v + one)
        |=> !stat_q[P_SF]);

    a_r7_supervisory_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_idle && !(rx_valid && rx_is_info)
        |=> $stable(nr_v) && $stable(stat_q[P_RF]));

    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_idle && (stat_q[P_RF] || stat_q[P_SF])
        |=> (stat_q[P_RF] || !$past(stat_q[P_RF])) && (stat_q[P_SF] || !$past(stat_q[P_SF])));

    a_r9_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_en && !cpu_bit_en |=> stat_q == $past(cpu_wr_data));

    a_r10_bit_write: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_bit_en |=> stat_q[$past(cpu_bit_sel)] == $past(cpu_bit_val));

endmodule

bind seqtrk_top seqtrk_checker #(.SEQ_W(SEQ_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_is_info  (rx_is_info),
    .rx_ns       (rx_ns),
    .rx_nr       (rx_nr),
    .tx_info     (tx_info),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_data (cpu_wr_data),
    .cpu_bit_en  (cpu_bit_en),
    .cpu_bit_sel (cpu_bit_sel),
    .cpu_bit_val (cpu_bit_val),
    .stat_q      (stat_q)
);

// File: tb/sim_seqtrk_top.sv
// Bench: directed and random stimulus with a behavioural reference model
// compared against stat_q after every clock.
module sim_seqtrk_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic       rx_is_info = 1'b0;
    logic [2:0] rx_ns = '0;
    logic [2:0] rx_nr = '0;
    logic       tx_info = 1'b0;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wr_data = '0;
    logic       cpu_bit_en = 1'b0;
    logic [2:0] cpu_bit_sel = '0;
    logic       cpu_bit_val = 1'b0;
    logic [7:0] stat_q;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 0;
    int  m_send = 0;
    int  m_recv = 0;
    bit  m_sflag = 0;
    bit  m_rflag = 0;

    always #4 clk = ~clk;

    seqtrk_top u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_is_info(rx_is_info),
        .rx_ns(rx_ns), .rx_nr(rx_nr), .tx_info(tx_info), .cpu_wr_en(cpu_wr_en),
        .cpu_wr_data(cpu_wr_data), .cpu_bit_en(cpu_bit_en), .cpu_bit_sel(cpu_bit_sel),
        .cpu_bit_val(cpu_bit_val), .stat_q(stat_q)
    );

    function automatic logic [7:0] model_byte();
        return {3'(m_send), m_sflag, 3'(m_recv), m_rflag};
    endfunction

    // Advance the reference model by one clock from the driven inputs.
    task automatic model_step();
        int send_before = m_send;
        logic [7:0] b;
        if (tx_info) m_send = (m_send + 1) % 8;
        if (rx_valid) begin
            if (rx_is_info) begin
                if (int'(rx_ns) == m_recv) m_recv = (m_recv + 1) % 8;
                else m_rflag = 1;
            end
            if (int'(rx_nr) != send_before && int'(rx_nr) != (send_before + 1) % 8)
                m_sflag = 1;
        end
        b = model_byte();
        if (cpu_wr_en) b = cpu_wr_data;
        if (cpu_bit_en) b[cpu_bit_sel] = cpu_bit_val;
        m_send = int'(b[7:5]); m_sflag = b[4]; m_recv = int'(b[3:1]); m_rflag = b[0];
    endtask

    // Clock once with the current inputs, then compare at the falling edge.
    task automatic step(input string tag);
        if (rst_n) model_step();
        else begin m_send = 0; m_recv = 0; m_sflag = 0; m_rflag = 0; end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (stat_q !== model_byte()) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, stat_q, model_byte());
        end
        rx_valid = 0; rx_is_info = 0; tx_info = 0; cpu_wr_en = 0; cpu_bit_en = 0;
    endtask

    task automatic rx_frame(input string tag, input bit info, input int ns, input int nr);
        rx_valid = 1; rx_is_info = info; rx_ns = 3'(ns); rx_nr = 3'(nr);
        step(tag);
    endtask

    task automatic cpu_write(input string tag, input logic [7:0] d);
        cpu_wr_en = 1; cpu_wr_data = d;
        step(tag);
    endtask

    task automatic cpu_bit(input string tag, input int sel, input bit v);
        cpu_bit_en = 1; cpu_bit_sel = 3'(sel); cpu_bit_val = v;
        step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: held in reset.
        step("R1");
        step("R1");
        rst_n = 1;
        step("R1");

        // R3: send counter wraps after eight frames.
        for (int i = 0; i < 9; i++) begin tx_info = 1; step("R3"); end

        // R4: in-order information frames, through the wrap. Acks kept in window.
        for (int i = 0; i < 9; i++) rx_frame("R4", 1, m_recv, m_send);

        // R5: out-of-order frame raises flag, counter held.
        rx_frame("R5", 1, (m_recv + 3) % 8, m_send);
        // R8: flag survives further good traffic.
        rx_frame("R8", 1, m_recv, m_send);
        step("R8");
        cpu_write("R9", 8'h00);

        // R2: field positions: send counter 5 then tx gives 6 in bits 7..5.
        cpu_write("R2", 8'hA0);
        tx_info = 1; step("R2");
        cpu_write("R2", 8'h0A);
        rx_frame("R2", 1, 5, 6);

        // R6: acknowledge window at the wrap, send counter preloaded to 7.
        cpu_write("R6", 8'hE0);
        rx_frame("R6", 0, 0, 7);
        rx_frame("R6", 0, 0, 0);
        // R6: window uses counter before same-cycle tx increment (7 -> 0, ack 1 bad).
        tx_info = 1; rx_valid = 1; rx_nr = 3'd1; step("R6");
        step("R8");

        // R7: supervisory frame with a bad send number leaves receive side alone.
        cpu_write("R7", 8'h00);
        rx_frame("R7", 0, 5, 0);

        // R9: byte write overrides same-cycle frame activity.
        tx_info = 1; rx_valid = 1; rx_is_info = 1; rx_ns = 3'd4; rx_nr = 3'd6;
        cpu_wr_en = 1; cpu_wr_data = 8'h33; step("R9");

        // R10: bit set/clear, bit beats byte write, others follow frame update.
        cpu_bit("R10", 0, 1);
        cpu_bit("R10", 4, 0);
        cpu_wr_en = 1; cpu_wr_data = 8'hFF; cpu_bit_en = 1; cpu_bit_sel = 3'd2;
        cpu_bit_val = 0; step("R10");
        tx_info = 1; cpu_bit_en = 1; cpu_bit_sel = 3'd1; cpu_bit_val = 1; step("R10");

        // Mixed random traffic against the model.
        for (int i = 0; i < 400; i++) begin
            rx_valid = ($urandom % 3) == 0;
            rx_is_info = $urandom % 2;
            rx_ns = 3'($urandom % 2 ? m_recv : $urandom);
            rx_nr = 3'($urandom % 4 ? m_send + ($urandom % 2) : $urandom);
            tx_info = ($urandom % 4) == 0;
            cpu_wr_en = ($urandom % 20) == 0;
            cpu_wr_data = 8'($urandom);
            cpu_bit_en = ($urandom % 15) == 0;
            cpu_bit_sel = 3'($urandom);
            cpu_bit_val = $urandom % 2;
            step("R2");
        end

        // R1: reset from a non-zero state.
        cpu_write("R1", 8'h5B);
        rst_n = 0; tx_info = 1; step("R1");
        rst_n = 1; step("R1");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule